// File: doc/BRIEF.md
# ACPI System Control Interrupt and APM Mode Controller

This block produces the level-sensitive system control interrupt (SCI) of a power-management function. It holds the 16-bit PM1 event status word. Event sources set bits in that word, and software clears them with write-one-to-clear strobes. The block combines the status word with the PM1 enable word and with the general-purpose event (GPE) status and enable bytes. Only four PM1 sources can raise the interrupt: timer overflow, global lock, power button and real-time clock. Only the hotplug bit can raise it from the GPE side.

The block also watches the most significant bit of the free-running PM timer. Each toggle of that bit sets the timer status bit. While the timer source is enabled and its status is clear, the block drives a timer-arm signal to the timer logic. The block handles writes to the APM control port. Two command codes move a two-state mode machine between legacy mode and ACPI mode. Any write to the port can also raise a one-cycle SMI pulse, gated by a bit of a configuration byte.

The mode machine has the states `MODE_LEGACY` (reset) and `MODE_ACPI`. A write of 0xF1 moves it from `MODE_LEGACY` to `MODE_ACPI`. A write of 0xF0 moves it from `MODE_ACPI` to `MODE_LEGACY`. Every other write leaves it where it is. The SMI machine has the states `SMI_IDLE` (reset) and `SMI_FIRE`. It enters `SMI_FIRE` for the one cycle after a gated port write, and otherwise it is in `SMI_IDLE`.

Top module: `acpi_sci_ctl`

## Requirements
- R1: After reset the status word is 0x0000, and `acpi_en_o`, `smi_o`, `sci_o` and `tmr_arm_o` are all low.
- R2: `sci_o` is high whenever (status AND PM1 enable) has a 1 in bit 0 (timer), bit 5 (global lock), bit 8 (power button) or bit 10 (RTC). Any other status bit, even when it is enabled, does not raise `sci_o`.
- R3: `sci_o` is high whenever bit 1 (hotplug) is set in both `gpe_sts_i` and `gpe_en_i`. The other GPE bits have no effect on `sci_o`.
- R4: `sci_o` is a level with no register on its path from the enable and GPE inputs. A change on those inputs shows on `sci_o` in the same cycle.
- R5: A cycle with `sts_clr_i` high clears, at the next edge, every status bit whose `sts_clr_mask_i` bit is 1. It leaves the other bits unchanged. `sci_o` falls in the cycle after the last enabled source bit is cleared.
- R6: A status bit that is set and cleared in the same cycle ends up set.
- R7: A cycle with `pwrbtn_req_i` high sets status bit 8 at the next edge.
- R8: A change of `tmr_msb_i` (rising or falling) relative to its value in the previous cycle sets status bit 0 at the next edge. `tmr_msb_i` is taken as 0 during reset.
- R9: `tmr_arm_o` is high exactly when PM1 enable bit 0 is 1 and status bit 0 is 0. When status bit 0 is set, `tmr_arm_o` drops in the same cycle.
- R10: An APM write of 0xF1 sets `acpi_en_o` at the next edge. An APM write of 0xF0 clears it. Any other value leaves it unchanged.
- R11: Each APM write made while bit 1 of `smi_cfg_i` is 1 gives `smi_o` high for exactly the following cycle. With that bit at 0, an APM write gives no pulse.
- R12: Status bits set through `sts_set_i` are held in the status word until they are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pm1_en_i | input | 16 | PM1 enable word |
| sts_set_i | input | 16 | Status set requests from other event sources |
| sts_clr_i | input | 1 | Write-one-to-clear strobe |
| sts_clr_mask_i | input | 16 | Bits to clear with the strobe |
| pwrbtn_req_i | input | 1 | Power-button request |
| tmr_msb_i | input | 1 | Most significant bit of the PM timer |
| gpe_sts_i | input | 8 | GPE status byte 0 |
| gpe_en_i | input | 8 | GPE enable byte 0 |
| apm_wr_i | input | 1 | APM control port write strobe |
| apm_data_i | input | 8 | APM control port write data |
| smi_cfg_i | input | 8 | Configuration byte; bit 1 enables SMI on APM writes |
| pm1_sts_o | output | 16 | PM1 status word |
| sci_o | output | 1 | System control interrupt level |
| smi_o | output | 1 | SMI pulse |
| acpi_en_o | output | 1 | ACPI mode enable bit |
| tmr_arm_o | output | 1 | Timer-overflow interrupt armed |

## Verification
The bench enables and sets status bits that are outside the SCI source set. A design with too wide a source mask would raise the interrupt for them. It sets a bit and clears the same bit in one cycle, where a design that gives the clear priority would lose a power-button event. It toggles the timer MSB in both directions, which catches a design that detects only rising edges. It sends APM command codes next to 0xF0 and 0xF1, which catches a partial decode that would flip the mode. It drops the SMI-enable bit, and a design that ignores it would pulse SMI anyway.

// File: rtl/acpi_sci_pkg.sv
package acpi_sci_pkg;
    localparam int PM1_W      = 16;
    localparam int GPE_W      = 8;
    localparam int CFG_W      = 8;
    localparam int APM_W      = 8;

    localparam int TMR_BIT    = 0;
    localparam int GBL_BIT    = 5;
    localparam int PWRBTN_BIT = 8;
    localparam int RTC_BIT    = 10;
    localparam int GPE_HP_BIT = 1;
    localparam int SMI_EN_BIT = 1;

    localparam logic [PM1_W-1:0] PM1_SCI_MASK =
        (PM1_W'(1) << TMR_BIT) | (PM1_W'(1) << GBL_BIT) |
        (PM1_W'(1) << PWRBTN_BIT) | (PM1_W'(1) << RTC_BIT);
    localparam logic [GPE_W-1:0] GPE_SCI_MASK = GPE_W'(1) << GPE_HP_BIT;

    localparam logic [APM_W-1:0] APM_CMD_ACPI_ON  = 8'hF1;
    localparam logic [APM_W-1:0] APM_CMD_ACPI_OFF = 8'hF0;

    typedef enum logic {
        MODE_LEGACY = 1'b0,
        MODE_ACPI   = 1'b1
    } mode_e;

    typedef enum logic {
        SMI_IDLE = 1'b0,
        SMI_FIRE = 1'b1
    } smi_e;
endpackage

// File: rtl/pm1_evt_status.sv
module pm1_evt_status
    import acpi_sci_pkg::*;
#(
    parameter int WIDTH = PM1_W,
    parameter int T_BIT = TMR_BIT,
    parameter int P_BIT = PWRBTN_BIT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_i,
    input  logic             pwrbtn_i,
    input  logic             tmr_msb_i,
    input  logic             clr_i,
    input  logic [WIDTH-1:0] clr_mask_i,
    output logic [WIDTH-1:0] sts_o
);
    logic             msb_q;
    logic             toggle;
    logic [WIDTH-1:0] set_all;
    logic [WIDTH-1:0] sts_q;

    always_ff @(posedge clk) begin
        if (!rst_n) msb_q <= 1'b0;
        else        msb_q <= tmr_msb_i;
    end

    assign toggle  = tmr_msb_i ^ msb_q;
    assign set_all = set_i | (WIDTH'(pwrbtn_i) << P_BIT) | (WIDTH'(toggle) << T_BIT);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)                        sts_q[b] <= 1'b0;
            else if (set_all[b])               sts_q[b] <= 1'b1;
            else if (clr_i && clr_mask_i[b])   sts_q[b] <= 1'b0;
        end
    end

    assign sts_o = sts_q;
endmodule

// File: rtl/sci_combine.sv
module sci_combine
    import acpi_sci_pkg::*;
#(
    parameter int                PW      = PM1_W,
    parameter int                GW      = GPE_W,
    parameter logic [PW-1:0]     PM_MASK = PM1_SCI_MASK,
    parameter logic [GW-1:0]     GP_MASK = GPE_SCI_MASK,
    parameter int                TBIT    = TMR_BIT
) (
    input  logic [PW-1:0] sts_i,
    input  logic [PW-1:0] en_i,
    input  logic [GW-1:0] gpe_sts_i,
    input  logic [GW-1:0] gpe_en_i,
    output logic          sci_o,
    output logic          tmr_arm_o
);
    logic pm_hit;
    logic gpe_hit;

    always_comb begin
        pm_hit    = |(sts_i & en_i & PM_MASK);
        gpe_hit   = |(gpe_sts_i & gpe_en_i & GP_MASK);
        sci_o     = pm_hit | gpe_hit;
        tmr_arm_o = en_i[TBIT] & ~sts_i[TBIT];
    end
endmodule

// File: rtl/apm_ctrl_fsm.sv
module apm_ctrl_fsm
    import acpi_sci_pkg::*;
#(
    parameter int DW    = APM_W,
    parameter int CW    = CFG_W,
    parameter int S_BIT = SMI_EN_BIT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic [DW-1:0] data_i,
    input  logic [CW-1:0] cfg_i,
    output logic          acpi_en_o,
    output logic          smi_o
);
    mode_e mode_q, mode_d;
    smi_e  smi_q,  smi_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_LEGACY;
            smi_q  <= SMI_IDLE;
        end else begin
            mode_q <= mode_d;
            smi_q  <= smi_d;
        end
    end

    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_LEGACY: if (wr_i && data_i == APM_CMD_ACPI_ON)  mode_d = MODE_ACPI;
            MODE_ACPI:   if (wr_i && data_i == APM_CMD_ACPI_OFF) mode_d = MODE_LEGACY;
            default:     mode_d = MODE_LEGACY;
        endcase
        smi_d = (wr_i && cfg_i[S_BIT]) ? SMI_FIRE : SMI_IDLE;
    end

    always_comb begin
        acpi_en_o = (mode_q == MODE_ACPI);
        smi_o     = (smi_q == SMI_FIRE);
    end
endmodule

// File: rtl/acpi_sci_ctl.sv
module acpi_sci_ctl
    import acpi_sci_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PM1_W-1:0] pm1_en_i,
    input  logic [PM1_W-1:0] sts_set_i,
    input  logic             sts_clr_i,
    input  logic [PM1_W-1:0] sts_clr_mask_i,
    input  logic             pwrbtn_req_i,
    input  logic             tmr_msb_i,
    input  logic [GPE_W-1:0] gpe_sts_i,
    input  logic [GPE_W-1:0] gpe_en_i,
    input  logic             apm_wr_i,
    input  logic [APM_W-1:0] apm_data_i,
    input  logic [CFG_W-1:0] smi_cfg_i,
    output logic [PM1_W-1:0] pm1_sts_o,
    output logic             sci_o,
    output logic             smi_o,
    output logic             acpi_en_o,
    output logic             tmr_arm_o
);
    pm1_evt_status u_sts (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (sts_set_i),
        .pwrbtn_i   (pwrbtn_req_i),
        .tmr_msb_i  (tmr_msb_i),
        .clr_i      (sts_clr_i),
        .clr_mask_i (sts_clr_mask_i),
        .sts_o      (pm1_sts_o)
    );

    sci_combine u_sci (
        .sts_i     (pm1_sts_o),
        .en_i      (pm1_en_i),
        .gpe_sts_i (gpe_sts_i),
        .gpe_en_i  (gpe_en_i),
        .sci_o     (sci_o),
        .tmr_arm_o (tmr_arm_o)
    );

    apm_ctrl_fsm u_apm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (apm_wr_i),
        .data_i    (apm_data_i),
        .cfg_i     (smi_cfg_i),
        .acpi_en_o (acpi_en_o),
        .smi_o     (smi_o)
    );
endmodule

// File: rtl/acpi_sci_ctl_chk.sv
module acpi_sci_ctl_chk
    import acpi_sci_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [PM1_W-1:0] pm1_en_i,
    input logic             sts_clr_i,
    input logic [PM1_W-1:0] sts_clr_mask_i,
    input logic             pwrbtn_req_i,
    input logic             tmr_msb_i,
    input logic [GPE_W-1:0] gpe_sts_i,
    input logic [GPE_W-1:0] gpe_en_i,
    input logic             apm_wr_i,
    input logic [APM_W-1:0] apm_data_i,
    input logic [CFG_W-1:0] smi_cfg_i,
    input logic [PM1_W-1:0] pm1_sts_o,
    input logic             sci_o,
    input logic             smi_o,
    input logic             acpi_en_o,
    input logic             tmr_arm_o
);
    logic msb_seen;
    always_ff @(posedge clk) begin
        if (!rst_n) msb_seen <= 1'b0;
        else        msb_seen <= tmr_msb_i;
    end

    AST_PWRBTN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        pwrbtn_req_i |=> pm1_sts_o[PWRBTN_BIT]); // R7

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (pwrbtn_req_i && sts_clr_i && sts_clr_mask_i[PWRBTN_BIT]) |=> pm1_sts_o[PWRBTN_BIT]); // R6

    AST_TMR_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_msb_i != msb_seen) |=> (pm1_sts_o[TMR_BIT] && !tmr_arm_o)); // R8

    AST_SCI_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|(pm1_sts_o & pm1_en_i & PM1_SCI_MASK)) && !(gpe_sts_i[GPE_HP_BIT] && gpe_en_i[GPE_HP_BIT])) |-> !sci_o); // R2

    AST_ACPI_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (apm_wr_i && apm_data_i == APM_CMD_ACPI_ON) |=> acpi_en_o); // R10

    AST_ACPI_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (apm_wr_i && apm_data_i == APM_CMD_ACPI_OFF) |=> !acpi_en_o); // R10

    AST_ACPI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(apm_wr_i && (apm_data_i == APM_CMD_ACPI_ON || apm_data_i == APM_CMD_ACPI_OFF)) |=> $stable(acpi_en_o)); // R10

    AST_SMI_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (apm_wr_i && smi_cfg_i[SMI_EN_BIT]) |=> smi_o); // R11

    AST_SMI_NO_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        !(apm_wr_i && smi_cfg_i[SMI_EN_BIT]) |=> !smi_o); // R11
endmodule

bind acpi_sci_ctl acpi_sci_ctl_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .pm1_en_i       (pm1_en_i),
    .sts_clr_i      (sts_clr_i),
    .sts_clr_mask_i (sts_clr_mask_i),
    .pwrbtn_req_i   (pwrbtn_req_i),
    .tmr_msb_i      (tmr_msb_i),
    .gpe_sts_i      (gpe_sts_i),
    .gpe_en_i       (gpe_en_i),
    .apm_wr_i       (apm_wr_i),
    .apm_data_i     (apm_data_i),
    .smi_cfg_i      (smi_cfg_i),
    .pm1_sts_o      (pm1_sts_o),
    .sci_o          (sci_o),
    .smi_o          (smi_o),
    .acpi_en_o      (acpi_en_o),
    .tmr_arm_o      (tmr_arm_o)
);

// File: tb/acpi_sci_ctl_tb_top.sv
`timescale 1ns/1ps
module acpi_sci_ctl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pm1_en_i = '0;
    logic [15:0] sts_set_i = '0;
    logic        sts_clr_i = 1'b0;
    logic [15:0] sts_clr_mask_i = '0;
    logic        pwrbtn_req_i = 1'b0;
    logic        tmr_msb_i = 1'b0;
    logic [7:0]  gpe_sts_i = '0;
    logic [7:0]  gpe_en_i = '0;
    logic        apm_wr_i = 1'b0;
    logic [7:0]  apm_data_i = '0;
    logic [7:0]  smi_cfg_i = '0;
    logic [15:0] pm1_sts_o;
    logic        sci_o, smi_o, acpi_en_o, tmr_arm_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    acpi_sci_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .pm1_en_i(pm1_en_i), .sts_set_i(sts_set_i),
        .sts_clr_i(sts_clr_i), .sts_clr_mask_i(sts_clr_mask_i),
        .pwrbtn_req_i(pwrbtn_req_i), .tmr_msb_i(tmr_msb_i),
        .gpe_sts_i(gpe_sts_i), .gpe_en_i(gpe_en_i), .apm_wr_i(apm_wr_i),
        .apm_data_i(apm_data_i), .smi_cfg_i(smi_cfg_i), .pm1_sts_o(pm1_sts_o),
        .sci_o(sci_o), .smi_o(smi_o), .acpi_en_o(acpi_en_o), .tmr_arm_o(tmr_arm_o)
    );

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic clear_all();
        sts_clr_i = 1'b1; sts_clr_mask_i = 16'hFFFF;
        step();
        sts_clr_i = 1'b0; sts_clr_mask_i = '0;
        #1;
    endtask

    task automatic t_reset();
        check("R1 status", pm1_sts_o, 16'h0000);
        check("R1 outs", {12'h0, sci_o, smi_o, acpi_en_o, tmr_arm_o}, 16'h0);
    endtask

    task automatic t_pwrbtn();
        pm1_en_i = 16'h0100;
        #1;
        check("R2 no sci before event", {15'h0, sci_o}, 16'h0);
        pwrbtn_req_i = 1'b1;
        step();
        pwrbtn_req_i = 1'b0;
        #1;
        check("R7 pwrbtn status", pm1_sts_o, 16'h0100);
        check("R2 sci from pwrbtn", {15'h0, sci_o}, 16'h1);
        pm1_en_i = 16'h0000;
        #1;
        check("R4 sci drops with enable", {15'h0, sci_o}, 16'h0);
        pm1_en_i = 16'h0100;
        #1;
        check("R4 sci rises with enable", {15'h0, sci_o}, 16'h1);
        sts_clr_i = 1'b1; sts_clr_mask_i = 16'h0020;
        step();
        check("R5 unmasked bit kept", pm1_sts_o, 16'h0100);
        sts_clr_mask_i = 16'h0100;
        #1;
        check("R5 sci high in clear cycle", {15'h0, sci_o}, 16'h1);
        step();
        sts_clr_i = 1'b0; sts_clr_mask_i = '0;
        #1;
        check("R5 cleared", pm1_sts_o, 16'h0000);
        check("R5 sci low after clear", {15'h0, sci_o}, 16'h0);
    endtask

    task automatic t_set_wins();
        pwrbtn_req_i = 1'b1; sts_clr_i = 1'b1; sts_clr_mask_i = 16'h0100;
        step();
        pwrbtn_req_i = 1'b0; sts_clr_i = 1'b0; sts_clr_mask_i = '0;
        #1;
        check("R6 set beats clear", pm1_sts_o, 16'h0100);
        clear_all();
    endtask

    task automatic t_sources();
        sts_set_i = 16'h8010;
        pm1_en_i  = 16'hFADE & ~16'h0521 | 16'h8010;
        step();
        sts_set_i = '0;
        #1;
        check("R12 other bits held", pm1_sts_o, 16'h8010);
        check("R2 non-source bits no sci", {15'h0, sci_o}, 16'h0);
        sts_set_i = 16'h0400; pm1_en_i = 16'h0400;
        step();
        sts_set_i = '0;
        #1;
        check("R2 rtc source", {15'h0, sci_o}, 16'h1);
        clear_all();
        sts_set_i = 16'h0020; pm1_en_i = 16'h0020;
        step();
        sts_set_i = '0;
        #1;
        check("R2 global lock source", {15'h0, sci_o}, 16'h1);
        clear_all();
        pm1_en_i = '0;
    endtask

    task automatic t_gpe();
        gpe_sts_i = 8'hFD; gpe_en_i = 8'hFF;
        #1;
        check("R3 other gpe bits", {15'h0, sci_o}, 16'h0);
        gpe_sts_i = 8'h02; gpe_en_i = 8'h02;
        #1;
        check("R3 hotplug bit", {15'h0, sci_o}, 16'h1);
        gpe_en_i = 8'h00;
        #1;
        check("R4 gpe enable drop", {15'h0, sci_o}, 16'h0);
        gpe_sts_i = '0;
    endtask

    task automatic t_timer();
        pm1_en_i = 16'h0001;
        #1;
        check("R9 armed", {15'h0, tmr_arm_o}, 16'h1);
        tmr_msb_i = 1'b1;
        step();
        #1;
        check("R8 rising toggle", pm1_sts_o, 16'h0001);
        check("R9 disarmed", {15'h0, tmr_arm_o}, 16'h0);
        check("R2 timer sci", {15'h0, sci_o}, 16'h1);
        clear_all();
        check("R9 rearmed", {15'h0, tmr_arm_o}, 16'h1);
        step();
        check("R8 steady msb no set", pm1_sts_o, 16'h0000);
        tmr_msb_i = 1'b0;
        step();
        check("R8 falling toggle", pm1_sts_o, 16'h0001);
        clear_all();
        pm1_en_i = '0;
        #1;
        check("R9 not armed when disabled", {15'h0, tmr_arm_o}, 16'h0);
    endtask

    task automatic apm_write(logic [7:0] d);
        apm_wr_i = 1'b1; apm_data_i = d;
        step();
        apm_wr_i = 1'b0; apm_data_i = '0;
    endtask

    task automatic t_apm();
        smi_cfg_i = 8'h02;
        apm_write(8'hF1);
        check("R10 acpi on", {15'h0, acpi_en_o}, 16'h1);
        check("R11 smi pulse", {15'h0, smi_o}, 16'h1);
        step();
        check("R11 smi one cycle", {15'h0, smi_o}, 16'h0);
        apm_write(8'hF3);
        check("R10 other code keeps on", {15'h0, acpi_en_o}, 16'h1);
        check("R11 smi on any write", {15'h0, smi_o}, 16'h1);
        smi_cfg_i = 8'hFD;
        apm_write(8'hF0);
        check("R10 acpi off", {15'h0, acpi_en_o}, 16'h0);
        check("R11 smi gated off", {15'h0, smi_o}, 16'h0);
        apm_write(8'hE1);
        check("R10 near code keeps off", {15'h0, acpi_en_o}, 16'h0);
        apm_write(8'h00);
        check("R10 zero keeps off", {15'h0, acpi_en_o}, 16'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        step();
        t_reset();
        t_pwrbtn();
        t_set_wins();
        t_sources();
        t_gpe();
        t_timer();
        t_apm();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule